// File: doc/BRIEF.md
# Gated Sync-Pulse Frequency Counter

This block measures the rate of a horizontal sync signal. Each of two channels counts active edges of the horizontal sync input over a gate interval. When the interval ends, the channel copies the count into a 10-bit result register and restarts from zero. A count that would pass 0x3FF stops at 0x3FF. Software can read that result at any time without disturbing the count in progress.

Each channel picks its gate from six sources:
- four fixed intervals, made by dividing the system clock;
- the time between two consecutive active edges of the auxiliary video input;
- the time between two consecutive active edges of the vertical sync input.

All three external inputs pass through two-flop synchronizers before edge detection. Each channel chooses its own active polarity for the pulse input and for the gate input.

The block is controlled through a small register port: an address, a write strobe, an 8-bit write data bus and a 16-bit combinational read bus. A global off bit turns the whole function off to save power. The shortest fixed interval is `BASE_TICKS` system clocks. The other three are 2, 4 and 8 times that length. With a 12 MHz clock the default gives about 1, 2, 4 and 8 ms.

Top module: `hsync_gate_counter`

## Requirements
- R1: After reset, every register reads 0. Because the reset select is 0, both channels start counting on the shortest fixed interval.
- R2: With select 4 (gate from the auxiliary input) or 5 (gate from vertical sync), the first active gate edge after arming only starts the interval. Each later gate edge stores the number of active pulse edges seen since the previous gate edge.
- R3: The running count stops at 0x3FF. For an interval with N active pulse edges, the stored result is min(N, 0x3FF).
- R4: Selects 0 to 3 gate on a free-running prescaler. The interval is BASE_TICKS << select clocks. The first boundary after arming only starts counting.
- R5: A pulse edge seen in the same cycle as a gate boundary is counted in the new interval, not in the interval being stored.
- R6: Any write to a channel's control register clears that channel's count and disarms it. The stored result keeps its old value until the next complete interval.
- R7: Selects 6 and 7 hold the channel idle with its count at zero. The result register keeps its value.
- R8: Bit 0 of address 0, when 1, turns the function off. The counts and the prescaler are forced to zero, nothing is counted or stored, and results are kept. After the bit returns to 0, each channel re-arms on its next boundary.
- R9: Control bits: [2:0] select, bit 3 set means pulses count on falling edges (else rising), bit 4 set means gate edges are falling (else rising).
- R10: The two channels count, gate and store independently of each other.
- R11: Register map:
  - address 0: global control.
  - addresses 1 and 2: control of channels 0 and 1, reading back bits [4:0].
  - addresses 3 and 4: results of channels 0 and 1, zero-extended to 16 bits.
  - any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hsync_i | input | 1 | Horizontal sync pulses to be counted (asynchronous) |
| vi_i | input | 1 | Auxiliary video gate input (asynchronous) |
| vsync_i | input | 1 | Vertical sync gate input (asynchronous) |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Write strobe, one cycle per write |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 16 | Read data for reg_addr_i, combinational |

## Verification
The assertions assume that each external input holds every level for at least two system clocks, so that the synchronizer sees every pulse and gate edge once. The bench drives pulses two clocks high and two clocks low, and holds gate levels for three clocks. Random pulse counts and fixed-period pulse trains stay within that limit. The bench writes registers with one-cycle strobes, always between complete gate edges, so each write lands as a single clearing event.

// File: rtl/hgc_pkg.sv
package hgc_pkg;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned NUM_FIX = 4;
  localparam int unsigned CTRL_W  = SEL_W + 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_FIX0 = 3'd0,
    SEL_FIX1 = 3'd1,
    SEL_FIX2 = 3'd2,
    SEL_FIX3 = 3'd3,
    SEL_AUX  = 3'd4,
    SEL_VERT = 3'd5,
    SEL_RSV6 = 3'd6,
    SEL_RSV7 = 3'd7
  } gate_sel_e;

  typedef struct packed {
    logic      gate_fall;
    logic      pulse_fall;
    gate_sel_e sel;
  } ch_ctrl_t;
endpackage

// File: rtl/hgc_rst_sync.sv
module hgc_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_no = stage_q[1];
endmodule

// File: rtl/hgc_edge_sync.sv
module hgc_edge_sync #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;
  assign fall_o = ~sync_q & prev_q;
endmodule

// File: rtl/hgc_prescaler.sv
module hgc_prescaler #(
  parameter int unsigned BASE_TICKS = 12288,
  parameter int unsigned NUM_FIX    = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  output logic [NUM_FIX-1:0] gate_o
);
  localparam int unsigned BASE_W = (BASE_TICKS > 2) ? $clog2(BASE_TICKS) : 1;
  localparam int unsigned OCT_W  = (NUM_FIX > 1) ? NUM_FIX - 1 : 1;
  localparam logic [BASE_W-1:0] BASE_LAST = BASE_W'(BASE_TICKS - 1);

  logic [BASE_W-1:0] base_q, base_d;
  logic [OCT_W-1:0]  oct_q, oct_d;
  logic              base_tick;

  assign base_tick = (base_q == BASE_LAST);

  always_comb begin
    base_d = base_q;
    oct_d  = oct_q;
    if (clr_i) begin
      base_d = '0;
      oct_d  = '0;
    end else if (base_tick) begin
      base_d = '0;
      oct_d  = oct_q + OCT_W'(1);
    end else begin
      base_d = base_q + BASE_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      oct_q  <= '0;
    end else begin
      base_q <= base_d;
      oct_q  <= oct_d;
    end
  end

  for (genvar k = 0; k < NUM_FIX; k++) begin : g_gate
    if (k == 0) begin : g_base
      assign gate_o[k] = base_tick;
    end else begin : g_oct
      localparam logic [OCT_W-1:0] MASK = OCT_W'((1 << k) - 1);
      assign gate_o[k] = base_tick && ((oct_q & MASK) == MASK);
    end
  end
endmodule

// File: rtl/hgc_channel.sv
module hgc_channel
  import hgc_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  ch_ctrl_t           ctrl_i,
  input  logic [NUM_FIX-1:0] fix_gate_i,
  input  logic               pulse_rise_i,
  input  logic               pulse_fall_i,
  input  logic               aux_rise_i,
  input  logic               aux_fall_i,
  input  logic               vert_rise_i,
  input  logic               vert_fall_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [CNT_W-1:0]   res_o,
  output logic               bnd_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d, res_q, res_d;
  logic             armed_q, armed_d;
  logic             pulse_ev, bnd, idle, res_en;

  assign pulse_ev = ctrl_i.pulse_fall ? pulse_fall_i : pulse_rise_i;

  always_comb begin
    bnd  = 1'b0;
    idle = 1'b0;
    unique case (ctrl_i.sel)
      SEL_FIX0, SEL_FIX1, SEL_FIX2, SEL_FIX3:
        bnd = fix_gate_i[ctrl_i.sel[1:0]];
      SEL_AUX:  bnd = ctrl_i.gate_fall ? aux_fall_i  : aux_rise_i;
      SEL_VERT: bnd = ctrl_i.gate_fall ? vert_fall_i : vert_rise_i;
      default:  idle = 1'b1;
    endcase
  end

  assign res_en = !clr_i && !idle && bnd && armed_q;

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    res_d   = res_q;
    if (clr_i || idle) begin
      cnt_d   = '0;
      armed_d = 1'b0;
    end else if (bnd) begin
      armed_d = 1'b1;
      cnt_d   = pulse_ev ? CNT_W'(1) : '0;
    end else if (armed_q && pulse_ev && (cnt_q != CNT_MAX)) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
    if (res_en) res_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      res_q   <= '0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      res_q   <= res_d;
    end
  end

  assign cnt_o = cnt_q;
  assign res_o = res_q;
  assign bnd_o = bnd && !idle;
endmodule

// File: rtl/hsync_gate_counter.sv
module hsync_gate_counter
  import hgc_pkg::*;
#(
  parameter int unsigned BASE_TICKS = 12288,
  parameter int unsigned CNT_W      = 10,
  parameter int unsigned NCH        = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        hsync_i,
  input  logic        vi_i,
  input  logic        vsync_i,
  input  logic [2:0]  reg_addr_i,
  input  logic        reg_wr_i,
  input  logic [7:0]  reg_wdata_i,
  output logic [15:0] reg_rdata_o
);
  localparam logic [2:0] ADDR_GLB  = 3'd0;
  localparam int unsigned ADDR_CTL = 1;
  localparam int unsigned ADDR_RES = 1 + NCH;

  logic rst_n;
  logic off_q, off_d;
  ch_ctrl_t [NCH-1:0] ctrl_q, ctrl_d;

  logic [2:0]                 rise, fall;
  logic [NUM_FIX-1:0]         fix_gate;
  logic [NCH-1:0]             ch_clr, ch_bnd;
  logic [NCH-1:0][CNT_W-1:0]  ch_cnt, ch_res;
  logic [NCH-1:0][SEL_W-1:0]  ch_sel;

  hgc_rst_sync u_rst (.clk_i(clk_i), .rst_ni(rst_ni), .rst_no(rst_n));

  hgc_edge_sync #(.W(3)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_n),
    .async_i({vsync_i, vi_i, hsync_i}),
    .rise_o(rise), .fall_o(fall)
  );

  hgc_prescaler #(.BASE_TICKS(BASE_TICKS), .NUM_FIX(NUM_FIX)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_n), .clr_i(off_q), .gate_o(fix_gate)
  );

  always_comb begin
    off_d  = off_q;
    ctrl_d = ctrl_q;
    if (reg_wr_i) begin
      if (reg_addr_i == ADDR_GLB) off_d = reg_wdata_i[0];
      for (int i = 0; i < NCH; i++) begin
        if (reg_addr_i == 3'(ADDR_CTL + i)) ctrl_d[i] = ch_ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      off_q  <= 1'b0;
      ctrl_q <= '0;
    end else begin
      off_q  <= off_d;
      ctrl_q <= ctrl_d;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign ch_clr[i] = off_q || (reg_wr_i && (reg_addr_i == 3'(ADDR_CTL + i)));
    assign ch_sel[i] = ctrl_q[i].sel;

    hgc_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i(clk_i), .rst_ni(rst_n), .clr_i(ch_clr[i]), .ctrl_i(ctrl_q[i]),
      .fix_gate_i(fix_gate),
      .pulse_rise_i(rise[0]), .pulse_fall_i(fall[0]),
      .aux_rise_i(rise[1]),   .aux_fall_i(fall[1]),
      .vert_rise_i(rise[2]),  .vert_fall_i(fall[2]),
      .cnt_o(ch_cnt[i]), .res_o(ch_res[i]), .bnd_o(ch_bnd[i])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_GLB) reg_rdata_o = {15'b0, off_q};
    for (int i = 0; i < NCH; i++) begin
      if (reg_addr_i == 3'(ADDR_CTL + i)) reg_rdata_o = 16'(ctrl_q[i]);
      if (reg_addr_i == 3'(ADDR_RES + i)) reg_rdata_o = 16'(ch_res[i]);
    end
  end
endmodule

// File: rtl/hgc_checker.sv
module hgc_checker #(
  parameter int unsigned NCH   = 2,
  parameter int unsigned CNT_W = 10
) (
  input logic                       clk_i,
  input logic                       rst_n,
  input logic                       off,
  input logic [NCH-1:0]             clr,
  input logic [NCH-1:0]             bnd,
  input logic [NCH-1:0][2:0]        sel,
  input logic [NCH-1:0][CNT_W-1:0]  cnt,
  input logic [NCH-1:0][CNT_W-1:0]  res
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    AST_OFF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n)
      off |=> cnt[i] == '0); // R8
    AST_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
      (cnt[i] == CMAX && !bnd[i] && !clr[i]) |=> cnt[i] == CMAX); // R3
    AST_RES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
      (!bnd[i] || clr[i]) |=> $stable(res[i])); // R6
    AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_n)
      (!bnd[i] && !clr[i]) |=> CNT_W'(cnt[i] - $past(cnt[i])) <= CNT_W'(1)); // R2
    AST_RSV_IDLE: assert property (@(posedge clk_i) disable iff (!rst_n)
      (sel[i][2:1] == 2'b11) |=> cnt[i] == '0); // R7
  end
endmodule

bind hsync_gate_counter hgc_checker #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_n(rst_n), .off(off_q), .clr(ch_clr), .bnd(ch_bnd),
  .sel(ch_sel), .cnt(ch_cnt), .res(ch_res)
);

// File: tb/hsync_gate_counter_tb.sv
module hsync_gate_counter_tb;
  localparam int unsigned BASE = 8;

  logic        clk, rst_n, hs, vi, vs, wr, hs_run;
  logic [2:0]  addr;
  logic [7:0]  wdata;
  logic [15:0] rdata;
  int checks, errors, cyc;
  logic done;

  hsync_gate_counter #(.BASE_TICKS(BASE)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .hsync_i(hs), .vi_i(vi), .vsync_i(vs),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int sat(input int n);
    return (n > 1023) ? 1023 : n;
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output int v);
    @(posedge clk); #1;
    addr = a;
    @(negedge clk);
    v = int'(rdata);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      hs = 1'b1; cycles(2);
      hs = 1'b0; cycles(2);
    end
  endtask

  task automatic vs_rise();
    vs = 1'b1; cycles(3);
    vs = 1'b0; cycles(3);
  endtask

  task automatic vi_rise();
    vi = 1'b1; cycles(3);
    vi = 1'b0; cycles(3);
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !done) begin
        errors++; checks++;
        $display("FAIL watchdog: got %0d expected below 150000", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      if (hs_run) begin
        hs = 1'b1; cycles(2);
        hs = 1'b0; cycles(1);
      end
    end
  end

  initial begin
    int v, a, b;
    logic [31:0] seed;
    checks = 0; errors = 0; done = 1'b0;
    seed = $urandom(32'h5eed_1234);
    hs = 0; vi = 0; vs = 0; wr = 0; addr = 0; wdata = 0; hs_run = 0;
    rst_n = 1'b0;
    cycles(4);
    rst_n = 1'b1;
    cycles(4);

    // R1 / R11: reset values and unused addresses
    for (int k = 0; k < 8; k++) begin
      rd_reg(3'(k), v);
      chk((k < 5) ? "R1" : "R11", v, 0);
    end

    // R11: control readback
    wr_reg(3'd2, 8'h1d);
    rd_reg(3'd2, v); chk("R11", v, 8'h1d);

    // R2: vertical sync gate with random counts
    wr_reg(3'd1, 8'h05);
    vs_rise();
    for (int t = 0; t < 8; t++) begin
      int n;
      n = $urandom_range(30, 0);
      pulses(n);
      vs_rise();
      rd_reg(3'd3, v); chk("R2", v, sat(n));
    end

    // R10: ch1 on aux input, ch0 on vertical sync, overlapping intervals
    wr_reg(3'd2, 8'h04);
    a = $urandom_range(20, 1);
    b = $urandom_range(20, 1);
    vi_rise(); vs_rise();
    pulses(a); vi_rise();
    pulses(b); vs_rise();
    rd_reg(3'd4, v); chk("R10", v, a);
    rd_reg(3'd3, v); chk("R10", v, a + b);

    // R3: saturation boundaries
    pulses(1022); vs_rise();
    rd_reg(3'd3, v); chk("R3", v, sat(1022));
    pulses(1023); vs_rise();
    rd_reg(3'd3, v); chk("R3", v, sat(1023));
    pulses(1100); vs_rise();
    rd_reg(3'd3, v); chk("R3", v, sat(1100));

    // R5: pulse edge coincident with gate edge goes to new interval
    pulses(3);
    hs = 1'b1; vs = 1'b1; cycles(3);
    hs = 1'b0; vs = 1'b0; cycles(4);
    rd_reg(3'd3, v); chk("R5", v, 3);
    pulses(2); vs_rise();
    rd_reg(3'd3, v); chk("R5", v, 3);

    // R9: falling gate and falling pulse polarity
    wr_reg(3'd1, 8'h1d);
    vs = 1'b1; cycles(3);
    hs = 1'b1; cycles(3);
    vs = 1'b0; cycles(3);
    hs = 1'b0; cycles(3);
    pulses(2);
    vs = 1'b1; cycles(3);
    pulses(1);
    hs = 1'b1; cycles(3);
    vs = 1'b0; cycles(6);
    hs = 1'b0; cycles(3);
    rd_reg(3'd3, v); chk("R9", v, 4);

    // R4: fixed intervals, pulse period 4 clocks
    hs_run = 1'b1;
    for (int k = 0; k < 4; k++) begin
      wr_reg(3'd1, 8'(k));
      cycles(3 * (BASE << k) + 20);
      rd_reg(3'd3, v); chk("R4", v, (BASE << k) / 4);
    end
    hs_run = 1'b0;
    cycles(6);

    // R6: control write discards partial interval, result held
    wr_reg(3'd1, 8'h05);
    vs_rise(); pulses(5); vs_rise();
    rd_reg(3'd3, v); chk("R6", v, 5);
    pulses(4);
    wr_reg(3'd1, 8'h05);
    rd_reg(3'd3, v); chk("R6", v, 5);
    vs_rise();
    rd_reg(3'd3, v); chk("R6", v, 5);
    pulses(7); vs_rise();
    rd_reg(3'd3, v); chk("R6", v, 7);

    // R7: reserved selects idle
    wr_reg(3'd1, 8'h06);
    vs_rise(); pulses(6); vs_rise(); vi_rise();
    rd_reg(3'd3, v); chk("R7", v, 7);
    wr_reg(3'd1, 8'h07);
    cycles(4 * (BASE << 3));
    rd_reg(3'd3, v); chk("R7", v, 7);

    // R8: global off retains results, no counting
    wr_reg(3'd1, 8'h05);
    wr_reg(3'd0, 8'h01);
    rd_reg(3'd0, v); chk("R8", v, 1);
    vs_rise(); pulses(9); vs_rise(); pulses(2); vs_rise();
    rd_reg(3'd3, v); chk("R8", v, 7);
    wr_reg(3'd0, 8'h00);
    vs_rise(); pulses(4); vs_rise();
    rd_reg(3'd3, v); chk("R8", v, 4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule